// File: doc/BRIEF.md
# Vectored Interrupt Controller Register Block

This block gathers ninety-six level-sensitive interrupt lines into three groups of thirty-two. It also drives a single interrupt request to the processor. Each group has four 32-bit registers: a latched pending word, a fast-path status word, an enable word and a mask word. One more register, the vector, names the lowest-numbered source that is pending, enabled and unmasked. Software reads the vector, services that source, clears the pending bit by writing a one to it, and reads the vector again until it reads zero.

Two further registers are provided. A protection register, when set, limits register writes to accesses flagged as privileged. An external-line trigger-type register is held for the pin logic around the block. The bus is a plain 32-bit word port with a byte address, a write strobe and a combinational read path. The register offsets are fixed, because the interrupt entry code decodes them.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero, `irq_o` is low and the vector reads zero.
- R2: Register offsets are as follows:
  - vector at 0x00
  - protection at 0x08
  - trigger type at 0x0C
  - pending of group n at 0x10+4n
  - fast-path status of group n at 0x20+4n
  - enable of group n at 0x40+4n
  - mask of group n at 0x50+4n

  Any other address, including a misaligned one, reads zero and ignores writes.
- R3: Source k is bit k%32 of group k/32. Its pending bit sets while the source is high, whatever its enable and mask.
- R4: Writing a pending word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R5: A source that is still high when its pending bit is cleared leaves that bit set.
- R6: A source whose enable bit is 0 neither raises `irq_o` nor appears in the vector.
- R7: A source whose mask bit is 1 neither raises `irq_o` nor appears in the vector. While it is high and enabled, its fast-path status bit sets. That bit is cleared by writing 1, as in R4.
- R8: The vector reads the lowest-numbered pending, enabled, unmasked source number in bits [8:2]. Bits [1:0] and [31:9] read 0, and the whole word reads 0 when no source qualifies, so source 0 is told apart only by `irq_o`.
- R9: The vector and `irq_o` follow the pending state one clock later. A source rising before clock edge N shows as pending after edge N and as `irq_o` after edge N+1.
- R10: While protection bit 0 is 1, register writes take effect only when `priv_i` is high.
- R11: The protection register holds bit 0 and the trigger-type register holds bits [1:0]. Both read back with the other bits zero.
- R12: The vector register is read-only: writes to 0x00 do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_i | input | 96 | Level-sensitive interrupt lines |
| bus_addr_i | input | 8 | Byte address of the register access |
| bus_wen_i | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| priv_i | input | 1 | Marks the current write as privileged |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The case that is hardest to reach from the ports is the clear-versus-set race. A one is written to a pending bit in the same cycle as its source is still high, so the set must win. The stimulus holds a source high, writes its clear bit, and reads the pending word back on the next cycle. The second hard case is a qualifying source that is masked while a higher-numbered one is also active. The stimulus raises both, checks the vector, then masks the lower one and checks that the vector moves to the other source and that the fast-path status bit sets.

// File: rtl/ivc_pkg.sv
// Shared types for the vectored interrupt controller.
// Assumes at most four groups per register region (two address bits).
package ivc_pkg;

    // Which register an access selects.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_VEC,
        SEL_PROT,
        SEL_TRIG,
        SEL_PEND,
        SEL_FAST,
        SEL_EN,
        SEL_MASK
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [1:0] grp;
    } reg_sel_t;

    localparam int unsigned TRIG_W = 2;

endpackage

// File: rtl/ivc_addr_dec.sv
// Address decoder: maps a byte address to a register kind and group index.
// Assumes NUM_GRP <= 4; unmapped or misaligned addresses yield SEL_NONE.
module ivc_addr_dec
    import ivc_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned NUM_GRP = 3
) (
    input  logic [ADDR_W-1:0] addr_i,
    output reg_sel_t          sel_o
);
    localparam int unsigned REGION_SHIFT = 4;

    logic [ADDR_W-1:0] high_part;
    logic [3:0]        region;
    logic [1:0]        slot;
    logic              aligned;
    logic              in_range;
    logic              grp_ok;

    assign high_part = addr_i >> 8;
    assign region    = 4'((addr_i >> REGION_SHIFT) & 'hF);
    assign slot      = addr_i[3:2];
    assign aligned   = (addr_i[1:0] == 2'b00);
    assign in_range  = (high_part == '0);
    assign grp_ok    = (32'(slot) < NUM_GRP);

    // Purpose: pick the register kind from the region and slot fields.
    always_comb begin
        sel_o.kind = SEL_NONE;
        sel_o.grp  = slot;
        if (aligned && in_range) begin
            unique case (region)
                4'h0: begin
                    if (slot == 2'd0)      sel_o.kind = SEL_VEC;
                    else if (slot == 2'd2) sel_o.kind = SEL_PROT;
                    else if (slot == 2'd3) sel_o.kind = SEL_TRIG;
                end
                4'h1: if (grp_ok) sel_o.kind = SEL_PEND;
                4'h2: if (grp_ok) sel_o.kind = SEL_FAST;
                4'h4: if (grp_ok) sel_o.kind = SEL_EN;
                4'h5: if (grp_ok) sel_o.kind = SEL_MASK;
                default: sel_o.kind = SEL_NONE;
            endcase
        end
    end

endmodule

// File: rtl/ivc_group.sv
// One group of interrupt sources: pending and fast-path latches (write-one-to-clear),
// enable and mask words. Assumes the write strobes are already qualified by protection.
module ivc_group #(
    parameter int unsigned GRP_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [GRP_W-1:0] src_i,
    input  logic [GRP_W-1:0] wdata_i,
    input  logic             wr_en_i,
    input  logic             wr_mask_i,
    input  logic             clr_pend_i,
    input  logic             clr_fast_i,
    output logic [GRP_W-1:0] pend_o,
    output logic [GRP_W-1:0] fast_o,
    output logic [GRP_W-1:0] en_o,
    output logic [GRP_W-1:0] mask_o,
    output logic [GRP_W-1:0] elig_o
);
    logic [GRP_W-1:0] pend_q, fast_q, en_q, mask_q;
    logic [GRP_W-1:0] pend_clr, fast_clr, fast_set;

    assign pend_clr = clr_pend_i ? wdata_i : '0;
    assign fast_clr = clr_fast_i ? wdata_i : '0;
    assign fast_set = src_i & en_q & mask_q;

    // Purpose: hold the enable and mask words written by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
        end else begin
            if (wr_en_i)   en_q   <= wdata_i;
            if (wr_mask_i) mask_q <= wdata_i;
        end
    end

    // Purpose: latch active sources; a live source wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            fast_q <= '0;
        end else begin
            pend_q <= (pend_q & ~pend_clr) | src_i;
            fast_q <= (fast_q & ~fast_clr) | fast_set;
        end
    end

    assign pend_o = pend_q;
    assign fast_o = fast_q;
    assign en_o   = en_q;
    assign mask_o = mask_q;
    assign elig_o = pend_q & en_q & ~mask_q;

    // R4: bits written as one with no live source are gone after the edge
    a_r4_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clr_pend_i |=> ((pend_q & $past(wdata_i & ~src_i)) == '0));

    // R4: without a clear strobe no pending bit falls
    a_r4_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_pend_i |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R5: a live source is pending on the next cycle regardless of clears
    a_r5_level_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (src_i != '0) |=> ((pend_q & $past(src_i)) == $past(src_i)));

endmodule

// File: rtl/ivc_prio_enc.sv
// Lowest-index priority encoder over the flattened eligible vector.
// Clock and reset feed only the embedded checks.
module ivc_prio_enc #(
    parameter int unsigned N     = 96,
    parameter int unsigned IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     req_i,
    output logic             valid_o,
    output logic [IDX_W-1:0] idx_o
);
    // Purpose: scan from the top so the lowest set index is the last one written.
    always_comb begin
        valid_o = |req_i;
        idx_o   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) idx_o = IDX_W'(i);
        end
    end

    // R8: the chosen index is set and nothing below it is set
    a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (req_i[idx_o] && ((req_i & ~({N{1'b1}} << idx_o)) == '0)));

endmodule

// File: rtl/irq_vector_ctrl.sv
// Vectored interrupt controller: register file, group latches, priority vector and IRQ.
// Assumes a single-cycle register bus; read data is combinational from the address.
module irq_vector_ctrl
    import ivc_pkg::*;
#(
    parameter int unsigned NUM_GRP = 3,
    parameter int unsigned GRP_W   = 32,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_GRP*GRP_W-1:0]   src_i,
    input  logic [ADDR_W-1:0]          bus_addr_i,
    input  logic                       bus_wen_i,
    input  logic [GRP_W-1:0]           bus_wdata_i,
    output logic [GRP_W-1:0]           bus_rdata_o,
    input  logic                       priv_i,
    output logic                       irq_o
);
    localparam int unsigned NUM_SRC = NUM_GRP * GRP_W;
    localparam int unsigned ID_W    = $clog2(NUM_SRC);
    localparam int unsigned VEC_PAD = GRP_W - ID_W - 2;

    reg_sel_t sel;
    logic     wr_ok;
    logic     prot_q;
    logic [TRIG_W-1:0] trig_q;
    logic [ID_W-1:0]   vec_id_q;
    logic              irq_q;

    logic [NUM_SRC-1:0] pend_all, fast_all, en_all, mask_all, elig_all;
    logic               enc_valid;
    logic [ID_W-1:0]    enc_idx;

    ivc_addr_dec #(.ADDR_W(ADDR_W), .NUM_GRP(NUM_GRP)) u_dec (
        .addr_i (bus_addr_i),
        .sel_o  (sel)
    );

    // Writes pass when protection is off or the access is privileged.
    assign wr_ok = bus_wen_i && (!prot_q || priv_i);

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        logic hit;
        assign hit = wr_ok && (32'(sel.grp) == g);

        ivc_group #(.GRP_W(GRP_W)) u_grp (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_i      (src_i[g*GRP_W +: GRP_W]),
            .wdata_i    (bus_wdata_i),
            .wr_en_i    (hit && sel.kind == SEL_EN),
            .wr_mask_i  (hit && sel.kind == SEL_MASK),
            .clr_pend_i (hit && sel.kind == SEL_PEND),
            .clr_fast_i (hit && sel.kind == SEL_FAST),
            .pend_o     (pend_all[g*GRP_W +: GRP_W]),
            .fast_o     (fast_all[g*GRP_W +: GRP_W]),
            .en_o       (en_all[g*GRP_W +: GRP_W]),
            .mask_o     (mask_all[g*GRP_W +: GRP_W]),
            .elig_o     (elig_all[g*GRP_W +: GRP_W])
        );
    end

    ivc_prio_enc #(.N(NUM_SRC), .IDX_W(ID_W)) u_enc (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (elig_all),
        .valid_o (enc_valid),
        .idx_o   (enc_idx)
    );

    // Purpose: hold the protection and trigger-type control words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_q <= 1'b0;
            trig_q <= '0;
        end else if (wr_ok) begin
            if (sel.kind == SEL_PROT) prot_q <= bus_wdata_i[0];
            if (sel.kind == SEL_TRIG) trig_q <= bus_wdata_i[TRIG_W-1:0];
        end
    end

    // Purpose: register the winning source and request one cycle after pending.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_id_q <= '0;
            irq_q    <= 1'b0;
        end else begin
            vec_id_q <= enc_valid ? enc_idx : '0;
            irq_q    <= enc_valid;
        end
    end

    assign irq_o = irq_q;

    // Purpose: return the selected register; unmapped addresses read zero.
    always_comb begin
        bus_rdata_o = '0;
        unique case (sel.kind)
            SEL_VEC:  bus_rdata_o = {{VEC_PAD{1'b0}}, vec_id_q, 2'b00};
            SEL_PROT: bus_rdata_o = GRP_W'(prot_q);
            SEL_TRIG: bus_rdata_o = GRP_W'(trig_q);
            SEL_PEND: bus_rdata_o = pend_all[sel.grp*GRP_W +: GRP_W];
            SEL_FAST: bus_rdata_o = fast_all[sel.grp*GRP_W +: GRP_W];
            SEL_EN:   bus_rdata_o = en_all[sel.grp*GRP_W +: GRP_W];
            SEL_MASK: bus_rdata_o = mask_all[sel.grp*GRP_W +: GRP_W];
            default:  bus_rdata_o = '0;
        endcase
    end

    // R6: a raised request traces back to an enabled pending source
    a_r6_irq_needs_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(pend_all & en_all) != '0));

    // R7: a raised request traces back to an unmasked pending source
    a_r7_irq_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(pend_all & ~mask_all) != '0));

    // R10: an unprivileged write under protection leaves enable and mask alone
    a_r10_prot_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_q && bus_wen_i && !priv_i) |=> ($stable(en_all) && $stable(mask_all)));

endmodule

// File: tb/sim_irq_vector_ctrl.sv
// Directed bench for irq_vector_ctrl: one task per scenario, each checking itself.
module sim_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [95:0] src = '0;
    logic [7:0]  addr = '0;
    logic        wen = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        priv = 1'b0;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    irq_vector_ctrl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src),
        .bus_addr_i  (addr),
        .bus_wen_i   (wen),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata),
        .priv_i      (priv),
        .irq_o       (irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; src = '0; wen = 1'b0; priv = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Write one word; returns on the negedge after the capturing edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wen = 1'b1;
        @(negedge clk);
        wen = 1'b0;
    endtask

    // Read combinationally at the current time (called away from the edge).
    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        @(negedge clk);
        check("R1 irq", 32'(irq), 0);
        foreach (u_list[i]) begin
            rd(u_list[i], d);
            check("R1 reg zero", d, 0);
        end
    endtask

    logic [7:0] u_list [14] = '{8'h00, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h20,
                                8'h24, 8'h28, 8'h40, 8'h44, 8'h48, 8'h50, 8'h58};

    task automatic t_map();
        logic [31:0] d;
        do_reset();
        wr(8'h44, 32'hA5A5_0001);
        wr(8'h58, 32'h0000_F00D);
        rd(8'h44, d); check("R2 enable grp1", d, 32'hA5A5_0001);
        rd(8'h58, d); check("R2 mask grp2", d, 32'h0000_F00D);
        rd(8'h40, d); check("R2 enable grp0 untouched", d, 0);
        wr(8'h4C, 32'hFFFF_FFFF);
        rd(8'h4C, d); check("R2 unmapped grp3 reads zero", d, 0);
        wr(8'h41, 32'hFFFF_FFFF);
        rd(8'h40, d); check("R2 misaligned write ignored", d, 0);
        rd(8'h45, d); check("R2 misaligned read zero", d, 0);
        rd(8'h04, d); check("R2 hole reads zero", d, 0);
    endtask

    task automatic t_pending_and_enable();
        logic [31:0] d;
        do_reset();
        @(negedge clk); src[40] = 1'b1;
        repeat (3) @(negedge clk);
        rd(8'h14, d); check("R3 source 40 -> grp1 bit8", d, 32'h0000_0100);
        check("R6 disabled no irq", 32'(irq), 0);
        rd(8'h00, d); check("R6 disabled no vector", d, 0);
    endtask

    task automatic t_w1c_and_level();
        logic [31:0] d;
        do_reset();
        @(negedge clk); src[40] = 1'b1; src[70] = 1'b1;
        @(negedge clk); src[40] = 1'b0;
        wr(8'h14, 32'h0000_0000);
        rd(8'h14, d); check("R4 zero write keeps", d, 32'h0000_0100);
        wr(8'h14, 32'h0000_0100);
        rd(8'h14, d); check("R4 one write clears", d, 0);
        wr(8'h18, 32'hFFFF_FFFF);
        rd(8'h18, d); check("R5 live source stays pending", d, 32'h0000_0040);
    endtask

    task automatic t_vector_timing();
        logic [31:0] d;
        do_reset();
        wr(8'h44, 32'h0000_0100);
        wr(8'h48, 32'h0000_0040);
        @(negedge clk); src[70] = 1'b1;
        @(negedge clk);
        rd(8'h18, d); check("R9 pending after first edge", d, 32'h0000_0040);
        check("R9 irq not yet", 32'(irq), 0);
        @(negedge clk);
        check("R9 irq after second edge", 32'(irq), 1);
        rd(8'h00, d); check("R8 vector source 70", d, 32'd280);
        src[40] = 1'b1;
        repeat (2) @(negedge clk);
        rd(8'h00, d); check("R8 lower source 40 wins", d, 32'd160);
        wr(8'h54, 32'h0000_0100);
        repeat (2) @(negedge clk);
        rd(8'h00, d); check("R7 masked 40 skipped", d, 32'd280);
        rd(8'h24, d); check("R7 fast status set", d, 32'h0000_0100);
        src[40] = 1'b0; src[70] = 1'b0;
        wr(8'h24, 32'h0000_0100);
        rd(8'h24, d); check("R7 fast status cleared", d, 0);
        wr(8'h18, 32'h0000_0040);
        wr(8'h14, 32'h0000_0100);
        repeat (2) @(negedge clk);
        check("R8 all clear irq low", 32'(irq), 0);
        rd(8'h00, d); check("R8 none reads zero", d, 0);
    endtask

    task automatic t_edges_of_range();
        logic [31:0] d;
        do_reset();
        wr(8'h40, 32'h0000_0001);
        @(negedge clk); src[0] = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 source 0 raises irq", 32'(irq), 1);
        rd(8'h00, d); check("R8 source 0 vector zero", d, 0);
        do_reset();
        wr(8'h48, 32'h8000_0000);
        @(negedge clk); src[95] = 1'b1;
        repeat (3) @(negedge clk);
        rd(8'h00, d); check("R8 source 95 vector", d, 32'h0000_017C);
        wr(8'h00, 32'hFFFF_FFFF);
        rd(8'h00, d); check("R12 vector read-only", d, 32'h0000_017C);
    endtask

    task automatic t_protection();
        logic [31:0] d;
        do_reset();
        wr(8'h0C, 32'hFFFF_FFFF);
        rd(8'h0C, d); check("R11 trigger type bits", d, 32'h0000_0003);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, d); check("R11 protection bit", d, 32'h0000_0001);
        wr(8'h40, 32'h1234_5678);
        rd(8'h40, d); check("R10 unprivileged write blocked", d, 0);
        priv = 1'b1;
        wr(8'h40, 32'h1234_5678);
        priv = 1'b0;
        rd(8'h40, d); check("R10 privileged write accepted", d, 32'h1234_5678);
    endtask

    initial begin
        t_reset();
        t_map();
        t_pending_and_enable();
        t_w1c_and_level();
        t_vector_timing();
        t_edges_of_range();
        t_protection();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule